// File: doc/BRIEF.md
# Write-Through Cache Tag Controller

This block models the tag side of a single-level write-through cache. Each accepted request carries a read/write flag and a 48-bit byte address. The block decides hit or miss against its tag store, allocates a line on a miss and keeps four traffic statistics: block reads from memory, writes to memory, hits and misses. No data is stored. The block only keeps account of what a real cache would move, so every write costs one memory write, and a write miss first costs a block fetch.

Cache size, block size and associativity are compile-time parameters, all powers of two. One design covers direct-mapped caches (one way), n-way set-associative caches and fully associative caches (one set holding every line). Victims are chosen by a separate first-in-first-out replacement unit. A probe flag on the same request port lets a prefetch sequencer test whether a block is present and fill it if it is not, without disturbing the hit and miss statistics.

Top module: `wt_tag_ctrl`

## Requirements
- R1: After reset every line is invalid, all four counters read zero, `rsp_valid` is low and `req_ready` goes high a few cycles after `rst_n` rises.
- R2: The address splits into a block offset of log2(BLOCK_BYTES) low bits, then a set index of log2(sets) bits, and the remaining upper bits up to bit 47 form the tag. Two addresses in the same block hit on each other, and addresses that differ only in bit 47 are different blocks.
- R3: A read that hits adds one to the hit counter and changes no other counter.
- R4: A read that misses adds one to the miss counter and one to the memory-read counter, and allocates the block.
- R5: Every non-probe write adds one to the memory-write counter. A write that hits also adds one to the hit counter and causes no memory read.
- R6: A write that misses adds one each to the miss, memory-read and memory-write counters, and allocates the block.
- R7: On a miss, if the set has an invalid way, the lowest-numbered invalid way is filled and no valid line is evicted.
- R8: When the set is full, the victim is the way filled longest ago. Hits do not change this order.
- R9: A request with `req_probe` high ignores `req_write` and never changes the hit, miss or memory-write counters. A probe that hits changes nothing, including the replacement order. A probe that misses fills the block like a miss and adds one memory read.
- R10: Counters are CNT_W bits (32 by default) and hold at all ones instead of wrapping.
- R11: `req_ready` stays high after reset. A request accepted on one rising edge gives `rsp_valid` high for exactly the next cycle, with `rsp_hit` showing the lookup result and the counters already updated. Back-to-back requests see each other's fills, and idle cycles change nothing.
- R12: The same behaviour holds for one way (direct-mapped), for power-of-two n ways, and for as many ways as lines (fully associative).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write access, 0 = read access (ignored for probes) |
| req_probe | input | 1 | 1 = prefetch presence check and fill |
| req_addr | input | 48 | Byte address |
| rsp_valid | output | 1 | Result of the request accepted on the previous edge |
| rsp_hit | output | 1 | 1 = block was present |
| cnt_mem_rd | output | CNT_W | Block reads from memory |
| cnt_mem_wr | output | CNT_W | Writes to memory |
| cnt_hit | output | CNT_W | Demand hits |
| cnt_miss | output | CNT_W | Demand misses |

## Verification
The bench drives four configurations with the same stream at once: two-way, direct-mapped, fully associative, and a two-way copy with 4-bit counters. A bench model predicts every response and counter value. Directed steps target FIFO order against recency: a design that refreshed the order on hits would evict the wrong line and miss on a block that should still be present. A probe hit followed by a conflict miss catches a design that advances replacement state on probe hits. A write miss catches designs that skip the block read or the memory write. Addresses differing only in bit 47 catch a truncated tag, and the 4-bit copy catches counters that wrap instead of holding.

// File: rtl/wt_tag_pkg.sv
package wt_tag_pkg;

  localparam int ADDR_W = 48;

  // one increment strobe per statistic; field order fixes counter slot
  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic hit;
    logic miss;
  } wt_bump_t;

endpackage

// File: rtl/wt_tag_lookup.sv
module wt_tag_lookup #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 40,
  parameter int WAY_W = 2
) (
  input  logic [WAYS*TAG_W-1:0] set_tags,
  input  logic [WAYS-1:0]       set_vld,
  input  logic [TAG_W-1:0]      key,
  output logic                  hit,
  output logic                  free_any,
  output logic [WAY_W-1:0]      free_way
);

  always_comb begin
    hit = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (set_vld[w] && (set_tags[w*TAG_W +: TAG_W] == key)) begin
        hit = 1'b1;
      end
    end
  end

  // scan downward so the lowest invalid way is the one left standing
  always_comb begin
    free_any = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!set_vld[w]) begin
        free_any = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

endmodule

// File: rtl/wt_fifo_repl.sv
module wt_fifo_repl #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int IDX_W = 4,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] look_idx,
  input  logic             adv,
  output logic [WAY_W-1:0] oldest
);

  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

  logic [WAY_W-1:0] ptr_q [SETS];
  logic [WAY_W-1:0] ptr_d [SETS];

  assign oldest = ptr_q[look_idx];

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      ptr_d[s] = ptr_q[s];
      if (adv && (look_idx == IDX_W'(s))) begin
        ptr_d[s] = (ptr_q[s] == LAST_WAY) ? '0 : ptr_q[s] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (adv) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= ptr_d[s];
    end
  end

endmodule

// File: rtl/wt_sat_ctr.sv
module wt_sat_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_en = inc && (cnt_q != TOP);
  assign cnt_d  = cnt_q + 1'b1;
  assign q      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/wt_tag_ctrl.sv
module wt_tag_ctrl
  import wt_tag_pkg::*;
#(
  parameter int CACHE_BYTES = 1024,
  parameter int BLOCK_BYTES = 16,
  parameter int WAYS        = 4,
  parameter int CNT_W       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_probe,
  input  logic [47:0]      req_addr,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [CNT_W-1:0] cnt_mem_rd,
  output logic [CNT_W-1:0] cnt_mem_wr,
  output logic [CNT_W-1:0] cnt_hit,
  output logic [CNT_W-1:0] cnt_miss
);

  localparam int LINES    = CACHE_BYTES / BLOCK_BYTES;
  localparam int SETS     = LINES / WAYS;
  localparam int OFF_W    = $clog2(BLOCK_BYTES);
  localparam int IDX_BITS = $clog2(SETS);
  localparam int IDX_W    = (IDX_BITS > 0) ? IDX_BITS : 1;
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TAG_W    = ADDR_W - OFF_W - IDX_BITS;

  // ---- reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_l = rst_pipe[1];

  logic rdy_q;
  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign req_ready = rdy_q;

  // ---- address split
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] key;
  logic             unused_offset;

  generate
    if (IDX_BITS > 0) begin : g_idx
      assign idx = req_addr[OFF_W +: IDX_BITS];
    end else begin : g_one_set
      assign idx = 1'b0;
    end
  endgenerate

  assign key           = req_addr[ADDR_W-1 -: TAG_W];
  assign unused_offset = ^req_addr[OFF_W-1:0];

  // ---- tag store
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  vld_d [SETS];
  logic [WAYS*TAG_W-1:0] set_tags;

  always_comb begin
    for (int w = 0; w < WAYS; w++) set_tags[w*TAG_W +: TAG_W] = tag_q[idx][w];
  end

  logic             look_hit;
  logic             free_any;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] oldest;
  logic [WAY_W-1:0] victim;
  logic             accept;
  logic             fill;

  wt_tag_lookup #(
    .WAYS (WAYS),
    .TAG_W(TAG_W),
    .WAY_W(WAY_W)
  ) u_lookup (
    .set_tags(set_tags),
    .set_vld (vld_q[idx]),
    .key     (key),
    .hit     (look_hit),
    .free_any(free_any),
    .free_way(free_way)
  );

  assign accept = req_valid && rdy_q;
  assign fill   = accept && !look_hit;
  assign victim = free_any ? free_way : oldest;

  wt_fifo_repl #(
    .SETS (SETS),
    .WAYS (WAYS),
    .IDX_W(IDX_W),
    .WAY_W(WAY_W)
  ) u_repl (
    .clk     (clk),
    .rst_n   (rst_l),
    .look_idx(idx),
    .adv     (fill),
    .oldest  (oldest)
  );

  always_comb begin
    vld_d = vld_q;
    if (fill) vld_d[idx][victim] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (fill) begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) tag_q[idx][victim] <= key;
  end

  // ---- response
  logic rsp_valid_q;
  logic rsp_hit_q;

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
    end else begin
      rsp_valid_q <= accept;
      if (accept) rsp_hit_q <= look_hit;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;

  // ---- statistics
  wt_bump_t         bump;
  logic [3:0]       bump_v;
  logic [CNT_W-1:0] cnt_q [4];

  always_comb begin
    bump.mem_rd = fill;
    bump.mem_wr = accept && req_write && !req_probe;
    bump.hit    = accept && !req_probe && look_hit;
    bump.miss   = accept && !req_probe && !look_hit;
  end
  assign bump_v = bump;

  generate
    for (genvar i = 0; i < 4; i++) begin : g_ctr
      wt_sat_ctr #(.W(CNT_W)) u_ctr (
        .clk  (clk),
        .rst_n(rst_l),
        .inc  (bump_v[i]),
        .q    (cnt_q[i])
      );
    end
  endgenerate

  assign cnt_mem_rd = cnt_q[3];
  assign cnt_mem_wr = cnt_q[2];
  assign cnt_hit    = cnt_q[1];
  assign cnt_miss   = cnt_q[0];

endmodule

// File: rtl/wt_tag_ctrl_chk.sv
module wt_tag_ctrl_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic             req_probe,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [CNT_W-1:0] cnt_mem_rd,
  input logic [CNT_W-1:0] cnt_mem_wr,
  input logic [CNT_W-1:0] cnt_hit,
  input logic [CNT_W-1:0] cnt_miss
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic seen_q;
  logic acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  assign acc = req_valid && req_ready;

  // R11: one response per accepted request, on the next cycle
  p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);
  p_no_spurious_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid);
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(cnt_mem_rd) && $stable(cnt_mem_wr) && $stable(cnt_hit) && $stable(cnt_miss)));

  // R3: a hit never fetches
  p_hit_no_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && rsp_valid && rsp_hit) |-> $stable(cnt_mem_rd));

  // R4: a miss always fetches
  p_miss_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && rsp_valid && !rsp_hit) |->
      ((cnt_mem_rd == $past(cnt_mem_rd) + 1'b1) || ($past(cnt_mem_rd) == TOP)));

  // R5: each demand write goes to memory
  p_write_through_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && !req_probe) |=>
      ((cnt_mem_wr == $past(cnt_mem_wr) + 1'b1) || ($past(cnt_mem_wr) == TOP)));

  // R6: hit and miss never both counted for one access
  p_single_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && rsp_valid) |-> !(($past(cnt_hit) != cnt_hit) && ($past(cnt_miss) != cnt_miss)));

  // R9: probes leave demand statistics alone
  p_probe_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_probe) |=> ($stable(cnt_hit) && $stable(cnt_miss) && $stable(cnt_mem_wr)));

  // R10: counters never go down and stay at all ones
  p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> ((cnt_hit >= $past(cnt_hit)) && (cnt_miss >= $past(cnt_miss)) &&
                (cnt_mem_rd >= $past(cnt_mem_rd)) && (cnt_mem_wr >= $past(cnt_mem_wr))));
  p_sat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && ($past(cnt_miss) == TOP)) |-> (cnt_miss == TOP));

endmodule

bind wt_tag_ctrl wt_tag_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_probe (req_probe),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .cnt_mem_rd(cnt_mem_rd),
  .cnt_mem_wr(cnt_mem_wr),
  .cnt_hit   (cnt_hit),
  .cnt_miss  (cnt_miss)
);

// File: tb/wt_tag_ctrl_test.sv
`timescale 1ns/1ps
module wt_tag_ctrl_test;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic        req_probe;
  logic [47:0] req_addr;

  logic        rdy [4];
  logic        rv  [4];
  logic        rh  [4];
  logic [31:0] crd [4];
  logic [31:0] cwr [4];
  logic [31:0] chit[4];
  logic [31:0] cmis[4];
  logic [3:0]  s_rd, s_wr, s_hit, s_mis;

  // cfg0: 64 B, 4 B blocks, 2 ways (8 sets)
  wt_tag_ctrl #(.CACHE_BYTES(64), .BLOCK_BYTES(4), .WAYS(2), .CNT_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[0]),
    .req_write(req_write), .req_probe(req_probe), .req_addr(req_addr),
    .rsp_valid(rv[0]), .rsp_hit(rh[0]), .cnt_mem_rd(crd[0]), .cnt_mem_wr(cwr[0]),
    .cnt_hit(chit[0]), .cnt_miss(cmis[0]));

  // cfg1: direct-mapped, 16 sets
  wt_tag_ctrl #(.CACHE_BYTES(64), .BLOCK_BYTES(4), .WAYS(1), .CNT_W(32)) uut_dm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[1]),
    .req_write(req_write), .req_probe(req_probe), .req_addr(req_addr),
    .rsp_valid(rv[1]), .rsp_hit(rh[1]), .cnt_mem_rd(crd[1]), .cnt_mem_wr(cwr[1]),
    .cnt_hit(chit[1]), .cnt_miss(cmis[1]));

  // cfg2: fully associative, 8 lines in one set
  wt_tag_ctrl #(.CACHE_BYTES(32), .BLOCK_BYTES(4), .WAYS(8), .CNT_W(32)) uut_fa (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[2]),
    .req_write(req_write), .req_probe(req_probe), .req_addr(req_addr),
    .rsp_valid(rv[2]), .rsp_hit(rh[2]), .cnt_mem_rd(crd[2]), .cnt_mem_wr(cwr[2]),
    .cnt_hit(chit[2]), .cnt_miss(cmis[2]));

  // cfg3: 2 ways, 2 sets, 4-bit counters
  wt_tag_ctrl #(.CACHE_BYTES(16), .BLOCK_BYTES(4), .WAYS(2), .CNT_W(4)) uut_sat (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[3]),
    .req_write(req_write), .req_probe(req_probe), .req_addr(req_addr),
    .rsp_valid(rv[3]), .rsp_hit(rh[3]), .cnt_mem_rd(s_rd), .cnt_mem_wr(s_wr),
    .cnt_hit(s_hit), .cnt_miss(s_mis));

  assign crd[3]  = {28'd0, s_rd};
  assign cwr[3]  = {28'd0, s_wr};
  assign chit[3] = {28'd0, s_hit};
  assign cmis[3] = {28'd0, s_mis};

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---- reference model
  int     cfg_sets[4] = '{8, 16, 1, 2};
  int     cfg_ways[4] = '{2, 1, 8, 2};
  longint cfg_max [4] = '{64'hFFFF_FFFF, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 64'd15};

  logic [47:0] mtag[4][16][8];
  bit          mval[4][16][8];
  int          mptr[4][16];
  longint      mrd[4], mwr[4], mhit[4], mmis[4];

  function automatic longint sat(longint v, longint m);
    return (v > m) ? m : v;
  endfunction

  task automatic model(int k, bit wr, bit pr, logic [47:0] a, output bit h);
    logic [47:0] blk;
    int s;
    int v;
    blk = a >> 2;
    s = int'(blk % longint'(cfg_sets[k]));
    h = 1'b0;
    for (int w = 0; w < cfg_ways[k]; w++)
      if (mval[k][s][w] && mtag[k][s][w] == blk) h = 1'b1;
    if (!h) begin
      v = -1;
      for (int w = 0; w < cfg_ways[k]; w++)
        if (!mval[k][s][w] && v < 0) v = w;
      if (v < 0) v = mptr[k][s];
      mptr[k][s] = (mptr[k][s] + 1) % cfg_ways[k];
      mval[k][s][v] = 1'b1;
      mtag[k][s][v] = blk;
      mrd[k]++;
    end
    if (!pr) begin
      if (wr) mwr[k]++;
      if (h) mhit[k]++; else mmis[k]++;
    end
  endtask

  // called at a falling edge; result sampled at the next falling edge
  task automatic access(bit wr, bit pr, logic [47:0] a, int exp_hit, string tag);
    bit h;
    req_valid = 1'b1;
    req_write = wr;
    req_probe = pr;
    req_addr  = a;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      model(k, wr, pr, a, h);
      chk("R11 rsp_valid", rv[k], 1);
      chk((k == 1 || k == 2) ? "R12 hit" : "R11 hit", rh[k], h);
      chk((k == 3) ? "R10 mem_rd" : (k == 0) ? "R4 mem_rd" : "R12 mem_rd", crd[k], sat(mrd[k], cfg_max[k]));
      chk((k == 3) ? "R10 mem_wr" : (k == 0) ? "R5 mem_wr" : "R12 mem_wr", cwr[k], sat(mwr[k], cfg_max[k]));
      chk((k == 3) ? "R10 hits" : (k == 0) ? "R3 hits" : "R12 hits", chit[k], sat(mhit[k], cfg_max[k]));
      chk((k == 3) ? "R10 misses" : (k == 0) ? "R6 misses" : "R12 misses", cmis[k], sat(mmis[k], cfg_max[k]));
    end
    if (exp_hit >= 0) chk(tag, rh[0], exp_hit);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic [31:0] hold_rd, hold_hit;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_probe = 1'b0;
    req_addr  = '0;
    for (int k = 0; k < 4; k++) begin
      mrd[k] = 0; mwr[k] = 0; mhit[k] = 0; mmis[k] = 0;
      for (int s = 0; s < 16; s++) begin
        mptr[k][s] = 0;
        for (int w = 0; w < 8; w++) begin
          mval[k][s][w] = 1'b0;
          mtag[k][s][w] = '0;
        end
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    for (int k = 0; k < 4; k++) begin
      chk("R1 ready", rdy[k], 1);
      chk("R1 rsp_valid", rv[k], 0);
      chk("R1 counters", crd[k] + cwr[k] + chit[k] + cmis[k], 0);
    end

    // directed sequence; literal expectations refer to cfg0 (index = addr[4:2])
    access(0, 0, 48'h100, 0, "R1 cold read misses");
    access(0, 0, 48'h103, 1, "R2 same block hits");
    access(0, 0, 48'h104, 0, "R2 next set misses");
    access(1, 0, 48'h120, 0, "R6 write miss");
    access(0, 0, 48'h100, 1, "R7 free way filled first");
    access(0, 0, 48'h140, 0, "R8 conflict miss");
    access(0, 0, 48'h120, 1, "R8 newer line kept");
    access(0, 0, 48'h100, 0, "R8 oldest line evicted despite hit");
    access(1, 0, 48'h140, 1, "R5 write hit");
    access(0, 1, 48'h400, 0, "R9 probe miss");
    access(1, 1, 48'h100, 1, "R9 probe hit");
    access(0, 0, 48'h500, 0, "R9 miss after probe");
    access(0, 0, 48'h400, 1, "R9 probe hit kept order");
    access(0, 0, 48'h100, 0, "R9 order victim");
    access(0, 0, 48'h8000_0000_0100, 0, "R2 bit 47 distinct tag");
    access(0, 0, 48'h8000_0000_0102, 1, "R2 bit 47 block hits");

    // R11: idle cycles change nothing
    req_valid = 1'b0;
    hold_rd  = crd[0];
    hold_hit = chit[0];
    repeat (3) @(negedge clk);
    chk("R11 idle rsp_valid", rv[0], 0);
    chk("R11 idle mem_rd", crd[0], hold_rd);
    chk("R11 idle hits", chit[0], hold_hit);

    // sweep: small address space, mixed reads, writes, probes
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      access(lfsr[10], (lfsr[13:11] == 3'b111), {lfsr[14], 38'd0, lfsr[8:0]}, -1, "");
    end
    req_valid = 1'b0;
    @(negedge clk);

    // R10: 4-bit counters held at 15
    chk("R10 sat mem_rd", crd[3], 15);
    chk("R10 sat mem_wr", cwr[3], 15);
    chk("R10 sat hits", chit[3], 15);
    chk("R10 sat misses", cmis[3], 15);
    chk("R10 wide not saturated", crd[0], sat(mrd[0], cfg_max[0]));

    summary();
    $finish;
  end

endmodule